// File: doc/BRIEF.md
# Polyphase Interpolator with Input Rate Control

This block is an integer-factor FIR interpolator built around a polyphase structure. It delivers one output sample per clock. A valid/ready handshake admits new input samples. Each admitted sample enters a short delay line, and the block then walks through its L polyphase branches, one branch per clock, producing L output samples. While it works through those branches it holds `ready` low, so the source is paced to at most one sample every L clocks. Samples offered while `ready` is low are dropped.

Coefficients come from an external table through a branch-indexed read port. The block drives the branch number it is computing. The table returns, in one packed row, every tap that belongs to that branch. A `coef_valid` flag from the coefficient side gates output validity. While it is low, computed phases are still consumed, but they are not marked valid.

The control is a two-state machine:
- **ST_IDLE**: waiting for a sample. `ready` is high.
- **ST_RUN**: stepping through the branches. `ready` is high only in the last branch.

It has four named transitions:
- **START**: ST_IDLE to ST_RUN when a sample is accepted.
- **STEP**: ST_RUN to ST_RUN, advancing to the next branch.
- **CHAIN**: ST_RUN to ST_RUN, back to branch 0, when a new sample is accepted during the last branch.
- **DRAIN**: ST_RUN to ST_IDLE after the last branch when no sample is offered.

Top module: `polyphase_interp`

## Requirements
- R1: Each accepted sample, meaning a cycle with `in_valid` and `ready` both high, causes exactly L compute cycles in branch order 0..L-1, starting the cycle after acceptance. The result of each compute cycle appears on `out_data` one cycle later. Result k equals the sum over j of h[k+j*L]*x[n-j], where x[n] is the newest accepted sample and all values are two's complement.
- R2: `ready` is low in the L-1 cycles that follow an acceptance cycle, and high in the cycle after those.
- R3: While no sample is offered, `ready` stays high indefinitely once the current branch sequence has ended.
- R4: With `in_valid` held high, exactly one sample is accepted every L clocks, and `out_valid` shows no gap between consecutive sequences.
- R5: A sample offered while `ready` is low changes neither the delay line nor the output sequence.
- R6: When `coef_valid` is low during a compute cycle, `out_valid` is low in the following cycle. The branch is still consumed.
- R7: During each compute cycle, `coef_addr` equals the branch index k. Slot j of `coef_row`, at bits [j*COEF_W +: COEF_W], must hold tap h[k+j*L].
- R8: During and right after reset, `ready` is high, `out_valid` is low, and the delay line holds zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a sample |
| in_data | input | DATA_W | Input sample, signed |
| ready | output | 1 | Block can accept a sample this cycle |
| coef_valid | input | 1 | Coefficient table holds a usable set |
| coef_addr | output | $clog2(FACTOR) | Branch index being computed |
| coef_row | input | PH_TAPS*COEF_W | Taps of the addressed branch, slot j = h[k+j*L] |
| out_valid | output | 1 | `out_data` holds a valid result |
| out_data | output | DATA_W+COEF_W+$clog2(PH_TAPS) | Interpolated output sample, signed |

## Verification
The critical coincidence is the CHAIN transition. In that cycle, the last branch of one sample is computed from the old delay line, and in the same cycle the next sample is accepted and shifted in. It is provoked by holding `in_valid` high for long stretches and by random valid patterns that land on the last branch. A bench model checks it: the model computes each branch result before applying that cycle's acceptance. Any off-by-one in the delay line update then shows up as a wrong value on the final phase, or a wrong value on the first phase of the next sample. A second overlap, `coef_valid` dropping in the middle of a sequence, is randomized. The expected `out_valid` pattern is judged cycle by cycle.

// File: rtl/interp_pkg.sv
package interp_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } ctl_state_e;
endpackage

// File: rtl/interp_rate_fsm.sv
module interp_rate_fsm
    import interp_pkg::*;
#(
    parameter int FACTOR = 4,
    localparam int PH_W = $clog2(FACTOR)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    output logic            ready,
    output logic            accept,
    output logic            running,
    output logic [PH_W-1:0] phase
);
    localparam logic [PH_W-1:0] LAST = PH_W'(FACTOR - 1);

    ctl_state_e      state, state_nx;
    logic [PH_W-1:0] phase_nx;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            phase <= '0;
        end else begin
            state <= state_nx;
            phase <= phase_nx;
        end
    end

    // next-state logic
    always_comb begin
        state_nx = state;
        phase_nx = phase;
        unique case (state)
            ST_IDLE: begin
                if (in_valid) begin          // START
                    state_nx = ST_RUN;
                    phase_nx = '0;
                end
            end
            ST_RUN: begin
                if (phase == LAST) begin
                    phase_nx = '0;
                    if (in_valid) state_nx = ST_RUN;   // CHAIN
                    else          state_nx = ST_IDLE;  // DRAIN
                end else begin
                    phase_nx = phase + 1'b1;           // STEP
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        ready   = (state == ST_IDLE) || (phase == LAST);
        accept  = in_valid && ready;
        running = (state == ST_RUN);
    end

    // R2
    ready_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> !ready);

    // R1
    phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (running && phase != LAST) |=> (running && phase == PH_W'($past(phase) + 1'b1)));

    // R1
    start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && ready) |=> (running && phase == '0));
endmodule

// File: rtl/interp_sample_line.sv
module interp_sample_line #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    shift_en,
    input  logic [DATA_W-1:0]       din,
    output logic [DEPTH*DATA_W-1:0] taps
);
    logic [DATA_W-1:0] stage_q [DEPTH];

    for (genvar s = 0; s < DEPTH; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (!rst_n) stage_q[s] <= '0;
            else if (shift_en) stage_q[s] <= (s == 0) ? din : stage_q[(s == 0) ? 0 : s - 1];
        end
        assign taps[s*DATA_W +: DATA_W] = stage_q[s];
    end

    // R5
    line_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(taps));
endmodule

// File: rtl/interp_branch_mac.sv
module interp_branch_mac #(
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 8,
    parameter int PH_TAPS = 4,
    localparam int PROD_W = DATA_W + COEF_W,
    localparam int ACC_W  = PROD_W + $clog2(PH_TAPS)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      run,
    input  logic                      coef_valid,
    input  logic [PH_TAPS*DATA_W-1:0] taps,
    input  logic [PH_TAPS*COEF_W-1:0] coef_row,
    output logic                      out_valid,
    output logic [ACC_W-1:0]          out_data
);
    logic signed [PROD_W-1:0] prod [PH_TAPS];
    logic signed [ACC_W-1:0]  acc;

    for (genvar j = 0; j < PH_TAPS; j++) begin : g_mul
        logic [DATA_W-1:0] x;
        logic [COEF_W-1:0] c;
        assign x = taps[j*DATA_W +: DATA_W];
        assign c = coef_row[j*COEF_W +: COEF_W];
        assign prod[j] = $signed({{COEF_W{x[DATA_W-1]}}, x}) *
                         $signed({{DATA_W{c[COEF_W-1]}}, c});
    end

    always_comb begin
        acc = '0;
        for (int j = 0; j < PH_TAPS; j++) begin
            acc = acc + $signed({{(ACC_W-PROD_W){prod[j][PROD_W-1]}}, prod[j]});
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= run && coef_valid;
            if (run) out_data <= acc;
        end
    end

    // R6
    quiet_output_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !coef_valid |=> !out_valid);

    // R1
    output_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(run));
endmodule

// File: rtl/polyphase_interp.sv
module polyphase_interp #(
    parameter int DATA_W  = 8,
    parameter int COEF_W  = 8,
    parameter int FACTOR  = 4,
    parameter int PH_TAPS = 4
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        in_valid,
    input  logic [DATA_W-1:0]                           in_data,
    output logic                                        ready,
    input  logic                                        coef_valid,
    output logic [$clog2(FACTOR)-1:0]                   coef_addr,
    input  logic [PH_TAPS*COEF_W-1:0]                   coef_row,
    output logic                                        out_valid,
    output logic [DATA_W+COEF_W+$clog2(PH_TAPS)-1:0]    out_data
);
    localparam int PH_W = $clog2(FACTOR);

    logic                       accept;
    logic                       running;
    logic [PH_W-1:0]            phase;
    logic [PH_TAPS*DATA_W-1:0]  taps;

    interp_rate_fsm #(.FACTOR(FACTOR)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .ready    (ready),
        .accept   (accept),
        .running  (running),
        .phase    (phase)
    );

    interp_sample_line #(.DATA_W(DATA_W), .DEPTH(PH_TAPS)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (accept),
        .din      (in_data),
        .taps     (taps)
    );

    interp_branch_mac #(.DATA_W(DATA_W), .COEF_W(COEF_W), .PH_TAPS(PH_TAPS)) u_mac (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (running),
        .coef_valid (coef_valid),
        .taps       (taps),
        .coef_row   (coef_row),
        .out_valid  (out_valid),
        .out_data   (out_data)
    );

    assign coef_addr = phase;

    // R8
    reset_ready_chk: assert property (@(posedge clk)
        !rst_n |=> (ready && !out_valid));
endmodule

// File: tb/polyphase_interp_test.sv
module polyphase_interp_test;
    localparam int DATA_W  = 8;
    localparam int COEF_W  = 8;
    localparam int L       = 4;
    localparam int PH_TAPS = 4;
    localparam int PH_W    = $clog2(L);
    localparam int ACC_W   = DATA_W + COEF_W + $clog2(PH_TAPS);

    logic                      clk = 1'b0;
    logic                      rst_n = 1'b0;
    logic                      in_valid = 1'b0;
    logic [DATA_W-1:0]         in_data = '0;
    logic                      ready;
    logic                      coef_valid = 1'b0;
    logic [PH_W-1:0]           coef_addr;
    logic [PH_TAPS*COEF_W-1:0] coef_row;
    logic                      out_valid;
    logic [ACC_W-1:0]          out_data;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    function automatic int coef_of(int tap);
        return ((tap * 37 + 11) % 61) - 30;
    endfunction

    for (genvar j = 0; j < PH_TAPS; j++) begin : g_rom
        assign coef_row[j*COEF_W +: COEF_W] = COEF_W'(coef_of(int'(coef_addr) + j * L));
    end

    polyphase_interp #(.DATA_W(DATA_W), .COEF_W(COEF_W), .FACTOR(L), .PH_TAPS(PH_TAPS)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data), .ready(ready),
        .coef_valid(coef_valid), .coef_addr(coef_addr), .coef_row(coef_row),
        .out_valid(out_valid), .out_data(out_data)
    );

    task automatic check(bit ok, string req, longint act, longint exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // reference model, evaluated mid-cycle
    int     hist [PH_TAPS];
    int     left = 0;
    bit     pend_valid = 1'b0;
    longint pend_data = 0;
    int     acc_cnt = 0;

    function automatic longint branch_sum(int k);
        longint s = 0;
        for (int j = 0; j < PH_TAPS; j++) s += longint'(coef_of(k + j * L)) * hist[j];
        return s;
    endfunction

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < PH_TAPS; i++) hist[i] = 0;
            left = 0;
            pend_valid = 1'b0;
        end else if (!done) begin
            bit exp_ready;
            exp_ready = (left <= 1);
            check(ready == exp_ready, (left > 1) ? "R2 ready" : "R3 ready", ready, exp_ready);
            check(out_valid == pend_valid, "R1/R6 out_valid", out_valid, pend_valid);
            if (pend_valid)
                check(longint'($signed(out_data)) == pend_data, "R1/R5 out_data",
                      longint'($signed(out_data)), pend_data);
            if (left > 0) begin
                check(int'(coef_addr) == L - left, "R7 coef_addr", coef_addr, L - left);
                pend_valid = coef_valid;
                pend_data  = branch_sum(L - left);
                left--;
            end else begin
                pend_valid = 1'b0;
            end
            if (in_valid && exp_ready) begin
                for (int i = PH_TAPS - 1; i > 0; i--) hist[i] = hist[i-1];
                hist[0] = int'($signed(in_data));
                left = L;
                acc_cnt++;
            end
        end
    end

    task automatic drive(bit v, bit cv);
        @(posedge clk); #1;
        in_valid   = v;
        coef_valid = cv;
        in_data    = DATA_W'($urandom);
    endtask

    initial begin
        void'($urandom(32'd1207));
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8 during reset
        check(ready == 1'b1, "R8 ready in reset", ready, 1);
        check(out_valid == 1'b0, "R8 out_valid in reset", out_valid, 0);
        @(posedge clk); #1 rst_n = 1'b1;
        @(negedge clk);
        check(ready == 1'b1 && out_valid == 1'b0, "R8 after reset", {ready, out_valid}, 2);

        // single sample at maximal positive value, then idle (R3)
        @(posedge clk); #1; in_valid = 1'b1; coef_valid = 1'b1; in_data = 8'h7F;
        drive(1'b0, 1'b1);
        repeat (12) drive(1'b0, 1'b1);

        // most negative sample, valid held during busy (R5)
        @(posedge clk); #1; in_valid = 1'b1; in_data = 8'h80;
        repeat (3) drive(1'b1, 1'b1);
        repeat (8) drive(1'b0, 1'b1);

        // valid held permanently high (R4)
        repeat (2 * L) drive(1'b1, 1'b1);
        begin
            int c0;
            @(negedge clk); #1 c0 = acc_cnt;
            fork
                repeat (8 * L) drive(1'b1, 1'b1);
            join_none
            repeat (8 * L) @(negedge clk);
            #1 check(acc_cnt - c0 == 8, "R4 accept count", acc_cnt - c0, 8);
            wait fork;
        end

        // coefficient flag withdrawn during a held stream (R6)
        repeat (3 * L) drive(1'b1, 1'b0);
        repeat (2 * L) drive(1'b1, 1'b1);

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            int mode;
            mode = n / 1000;
            drive(($urandom % 8) < (mode == 0 ? 2 : mode == 1 ? 5 : 8),
                  ($urandom % 8) != 0);
        end
        repeat (12) drive(1'b0, 1'b1);
        @(negedge clk); #2;
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            vectors++;
            fails++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end
endmodule